// File: doc/BRIEF.md
# Early-Reset Three-Level SAR Controller

This block is the sequencing and register logic of a differential successive-approximation converter. The converter's capacitor DAC has three levels per stage. Each binary-weighted capacitor pair rests at the common-mode level, or it has one bottom plate at the supply and the other at ground. A `start` request opens a sampling window. During that window every stage is parked at common mode. The controller then takes one comparator decision per clock and drives an UP/DN pair for each stage, starting at the largest capacitor. The analog array, the comparator and the sampling switches sit outside this block.

The first decision fixes the input polarity and steers the largest stage. Every later stage is driven with that same polarity, whatever the comparator says. When a decision disagrees with the first one, the stage set on the previous cycle is returned to common mode on the same edge. The DAC therefore never flips a capacitor in the opposite direction, and it still reaches the same residue as a conventional switching order. The final decision switches nothing. It is combined with the three-level stage pattern to form a plain offset-binary word. That word appears on `data_out` together with a one-cycle `done` strobe.

The result is a register, not a stream. It holds its value until the next conversion completes, so there is no back-pressure to handle. `done` is a status pulse that nobody acknowledges. `start` is a plain request: it is taken only while the block is idle.

Top module: `sar_er_ctrl`

## Requirements
- R1: While `rst_n` is low, `up`, `dn`, `sample`, `done` and `data_out` are all zero.
- R2: A `start` seen high at a clock edge while idle raises `sample` for exactly SAMP_CYC cycles. Throughout that window every bit of `up` and `dn` is 0, which is common mode for every stage.
- R3: The first comparator decision after sampling sets the largest stage (index N-2). A decision of 1 sets `up[N-2]` and a decision of 0 sets `dn[N-2]`.
- R4: The decision taken at conversion step i, for 1 <= i <= N-2, sets stage N-2-i with the first decision's polarity, whatever the value of `cmp_in`. At any time all active stages share one polarity.
- R5: When the decision at step i (1 <= i <= N-2) differs from the first decision, both bits of stage N-1-i are cleared on that same edge.
- R6: `up[k]` and `dn[k]` are never high together for any stage k.
- R7: Between consecutive cycles outside sampling, at most two stages change state: one set and at most one cleared.
- R8: The N-th decision raises `done` for exactly one cycle, starting at that edge. It also loads `data_out` with the offset-binary code whose bits, MSB first, are the N decisions in order. `data_out` is unchanged at all other times.
- R9: A `start` that arrives during sampling or conversion has no effect on the running conversion and does not open a new sampling window.
- R10: The final (N-th) decision leaves every stage unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Conversion request, taken only when idle |
| cmp_in | input | 1 | Comparator decision, 1 when the residue is positive |
| sample | output | 1 | High during the acquisition window |
| up | output | N-1 | Per-stage positive-side drive (positive plate to supply) |
| dn | output | N-1 | Per-stage negative-side drive (positive plate to ground) |
| data_out | output | N | Offset-binary result of the last conversion |
| done | output | 1 | One-cycle pulse when `data_out` is loaded |

## Verification
The bench builds the block with N=6 and SAMP_CYC=3. At that width every one of the 64 output codes, each with four sub-LSB input offsets, can be converted exhaustively against an ideal DAC and comparator model. Five stages still give early clears on the largest stage, on interior stages, and right before the final decision. A three-cycle sampling window leaves room to raise `start` in the middle of a conversion and watch that nothing moves.

// File: rtl/sar_er_pkg.sv
package sar_er_pkg;

  // Phase of the conversion sequencer
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SAMP = 2'd1,
    PH_CONV = 2'd2
  } phase_e;

endpackage

// File: rtl/sar_er_seq.sv
module sar_er_seq
  import sar_er_pkg::*;
#(
  parameter int N        = 10,
  parameter int SAMP_CYC = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  output logic                      sample,
  output logic                      conv,
  output logic                      clr_all,
  output logic                      last,
  output logic [$clog2(N)-1:0]      step
);
  localparam int STEP_W = $clog2(N);
  localparam int SCNT_W = (SAMP_CYC > 1) ? $clog2(SAMP_CYC) : 1;
  localparam logic [SCNT_W-1:0] SCNT_LAST = SCNT_W'(SAMP_CYC - 1);
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(N - 1);

  phase_e              phase_q;
  logic [SCNT_W-1:0]   scnt_q;
  logic [STEP_W-1:0]   step_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      scnt_q  <= '0;
      step_q  <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (start) begin
            phase_q <= PH_SAMP;
            scnt_q  <= '0;
          end
        end
        PH_SAMP: begin
          if (scnt_q == SCNT_LAST) begin
            phase_q <= PH_CONV;
            step_q  <= '0;
          end else begin
            scnt_q <= scnt_q + 1'b1;
          end
        end
        PH_CONV: begin
          if (step_q == STEP_LAST) begin
            phase_q <= PH_IDLE;
          end else begin
            step_q <= step_q + 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign sample  = (phase_q == PH_SAMP);
  assign conv    = (phase_q == PH_CONV);
  assign clr_all = (phase_q == PH_IDLE) && start;
  assign last    = conv && (step_q == STEP_LAST);
  assign step    = step_q;

endmodule

// File: rtl/sar_er_capbank.sv
module sar_er_capbank #(
  parameter int N = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr_all,
  input  logic                  conv,
  input  logic [$clog2(N)-1:0]  step,
  input  logic                  cmp_in,
  output logic                  pol,
  output logic [N-2:0]          up,
  output logic [N-2:0]          dn
);
  localparam int NS     = N - 1;
  localparam int STEP_W = $clog2(N);

  logic pol_q;
  logic first_step;
  logic pol_now;
  logic disagree;

  assign first_step = (step == '0);
  assign pol_now    = first_step ? cmp_in : pol_q;
  assign disagree   = !first_step && (cmp_in != pol_q);

  // Polarity of the input, held for the whole conversion
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pol_q <= 1'b0;
    end else if (conv && first_step) begin
      pol_q <= cmp_in;
    end
  end

  assign pol = pol_q;

  for (genvar k = 0; k < NS; k++) begin : g_stage
    localparam logic [STEP_W-1:0] SET_AT = STEP_W'(N - 2 - k);
    logic set_k;
    logic clr_k;
    logic up_q;
    logic dn_q;

    assign set_k = conv && (step == SET_AT);

    if (k > 0) begin : g_clr
      // stage k is the previous stage when step N-1-k is decided
      localparam logic [STEP_W-1:0] CLR_AT = STEP_W'(N - 1 - k);
      assign clr_k = conv && (step == CLR_AT) && disagree;
    end else begin : g_noclr
      // smallest stage: only the final decision follows it, which switches nothing
      assign clr_k = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        up_q <= 1'b0;
        dn_q <= 1'b0;
      end else if (clr_all || clr_k) begin
        up_q <= 1'b0;
        dn_q <= 1'b0;
      end else if (set_k) begin
        up_q <= pol_now;
        dn_q <= !pol_now;
      end
    end

    assign up[k] = up_q;
    assign dn[k] = dn_q;
  end

endmodule

// File: rtl/sar_er_recon.sv
module sar_er_recon #(
  parameter int N = 10
) (
  input  logic [N-2:0] up,
  input  logic [N-2:0] dn,
  input  logic         pol,
  input  logic         last_dec,
  output logic [N-1:0] code
);
  localparam logic [N:0] HALF = (N+1)'(2 ** (N - 1));
  localparam logic [N:0] ONE  = (N+1)'(1);

  logic [N:0] mag;
  logic [N:0] lsb;
  logic [N:0] sum;

  // All active stages share one polarity, so their weighted sum is a magnitude
  assign mag = {2'b00, (up | dn)};
  assign lsb = {{N{1'b0}}, last_dec};

  always_comb begin
    if (pol) begin
      sum = HALF + mag - ONE + lsb;
    end else begin
      sum = HALF - mag - ONE + lsb;
    end
  end

  assign code = sum[N-1:0];

endmodule

// File: rtl/sar_er_ctrl.sv
module sar_er_ctrl #(
  parameter int N        = 10,
  parameter int SAMP_CYC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         cmp_in,
  output logic         sample,
  output logic [N-2:0] up,
  output logic [N-2:0] dn,
  output logic [N-1:0] data_out,
  output logic         done
);
  localparam int STEP_W = $clog2(N);

  logic              conv;
  logic              clr_all;
  logic              last;
  logic [STEP_W-1:0] step;
  logic              pol;
  logic [N-1:0]      code;
  logic [N-1:0]      data_q;
  logic              done_q;

  sar_er_seq #(.N(N), .SAMP_CYC(SAMP_CYC)) seq_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .sample  (sample),
    .conv    (conv),
    .clr_all (clr_all),
    .last    (last),
    .step    (step)
  );

  sar_er_capbank #(.N(N)) bank_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_all (clr_all),
    .conv    (conv),
    .step    (step),
    .cmp_in  (cmp_in),
    .pol     (pol),
    .up      (up),
    .dn      (dn)
  );

  sar_er_recon #(.N(N)) recon_i (
    .up       (up),
    .dn       (dn),
    .pol      (pol),
    .last_dec (cmp_in),
    .code     (code)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last;
      if (last) begin
        data_q <= code;
      end
    end
  end

  assign data_out = data_q;
  assign done     = done_q;

endmodule

// File: rtl/sar_er_ctrl_chk.sv
module sar_er_ctrl_chk #(
  parameter int N = 10
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sample,
  input logic [N-2:0] up,
  input logic [N-2:0] dn,
  input logic [N-1:0] data_out,
  input logic         done
);

  AST_VCM_WHILE_SAMPLING: assert property (@(posedge clk) disable iff (!rst_n)
    sample |-> (up == '0 && dn == '0)); // R2

  AST_SINGLE_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
    !((|up) && (|dn))); // R4

  AST_NO_SHORTED_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (up & dn) == '0); // R6

  AST_TWO_STAGE_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample && !$past(sample)) |-> ($countones((up | dn) ^ $past(up | dn)) <= 2)); // R7

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(data_out)); // R8

  AST_FINAL_NO_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((up | dn) == $past(up | dn))); // R10

endmodule

bind sar_er_ctrl sar_er_ctrl_chk #(.N(N)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .sample   (sample),
  .up       (up),
  .dn       (dn),
  .data_out (data_out),
  .done     (done)
);

// File: tb/sar_er_ctrl_tb_top.sv
module sar_er_ctrl_tb_top;
  localparam int N    = 6;
  localparam int SAMP = 3;
  localparam int NS   = N - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          cmp_in = 1'b0;
  logic          sample;
  logic [NS-1:0] up;
  logic [NS-1:0] dn;
  logic [N-1:0]  data_out;
  logic          done;

  int n_chk = 0;
  int n_bad = 0;

  logic [NS-1:0] m_up;
  logic [NS-1:0] m_dn;
  logic          m_pol;

  always #10 clk = ~clk;

  sar_er_ctrl #(.N(N), .SAMP_CYC(SAMP)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cmp_in   (cmp_in),
    .sample   (sample),
    .up       (up),
    .dn       (dn),
    .data_out (data_out),
    .done     (done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Ideal DAC: signed sum of stage weights seen at the ports
  function automatic int dac_level();
    int acc = 0;
    for (int k = 0; k < NS; k++) begin
      if (up[k]) acc += (1 << k);
      if (dn[k]) acc -= (1 << k);
    end
    return acc;
  endfunction

  // vq: input in quarter-LSB units, 0 .. 4*2^N-1; expected code = vq/4
  task automatic convert(input int vq, input bit poke_busy);
    int clr_idx = -1;
    bit c;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int s = 0; s < SAMP; s++) begin
      check(sample == 1'b1, "R2", "sample during window", sample, 1);
      check(up == '0 && dn == '0, "R2", "stages at VCM while sampling", int'(up | dn), 0);
      @(negedge clk);
    end
    m_up = '0;
    m_dn = '0;
    for (int i = 0; i < N; i++) begin
      check(sample == 1'b0, "R2", "sample low in conversion", sample, 0);
      check(up == m_up, (i == 1) ? "R3" : "R4", "up pattern", up, m_up);
      check(dn == m_dn, (i == 1) ? "R3" : "R4", "dn pattern", dn, m_dn);
      check((up & dn) == '0, "R6", "no stage on both sides", int'(up & dn), 0);
      if (clr_idx >= 0)
        check(up[clr_idx] == 1'b0 && dn[clr_idx] == 1'b0, "R5",
              "previous stage cleared", int'({up[clr_idx], dn[clr_idx]}), 0);
      if (poke_busy && i == 2) start = 1'b1;
      if (i == 3) start = 1'b0;
      c = (vq >= 4 * ((1 << (N - 1)) + dac_level()));
      cmp_in = c;
      @(negedge clk);
      clr_idx = -1;
      if (i == 0) begin
        m_pol = c;
        m_up[NS-1] = c;
        m_dn[NS-1] = !c;
      end else if (i <= N - 2) begin
        m_up[NS-1-i] = m_pol;
        m_dn[NS-1-i] = !m_pol;
        if (c != m_pol) begin
          m_up[NS-i] = 1'b0;
          m_dn[NS-i] = 1'b0;
          clr_idx = NS - i;
        end
      end
    end
    check(done == 1'b1, "R8", "done after last decision", done, 1);
    check(data_out == N'(vq / 4), "R8", "result code", data_out, vq / 4);
    check(up == m_up && dn == m_dn, "R10", "final decision switches nothing",
          int'({up, dn}), int'({m_up, m_dn}));
    if (clr_idx >= 0) check(1'b0, "R10", "unexpected model clear", clr_idx, -1);
    @(negedge clk);
    check(done == 1'b0, "R8", "done lasts one cycle", done, 0);
    check(data_out == N'(vq / 4), "R8", "result held", data_out, vq / 4);
    check(sample == 1'b0, "R9", "no new window from busy start", sample, 0);
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd24681));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(up == '0 && dn == '0, "R1", "stages in reset", int'(up | dn), 0);
    check(sample == 1'b0 && done == 1'b0, "R1", "sample/done in reset", int'({sample, done}), 0);
    check(data_out == '0, "R1", "data_out in reset", data_out, 0);
    rst_n = 1'b1;

    // directed corners: extremes, mid-scale, alternating bit patterns
    convert(0, 1'b0);
    convert(4 * ((1 << N) - 1) + 3, 1'b0);
    convert(4 * (1 << (N - 1)), 1'b1);
    convert(4 * ((1 << (N - 1)) - 1) + 3, 1'b1);
    convert(4 * 6'b101010 + 1, 1'b0);
    convert(4 * 6'b010101 + 2, 1'b1);
    convert(4 * 6'b100000 + 1, 1'b0);
    convert(4 * 6'b011111, 1'b0);

    // exhaustive code sweep with sub-LSB offsets
    for (int v = 0; v < (1 << N); v++) begin
      for (int f = 0; f < 4; f++) begin
        convert(4 * v + f, (v % 5) == f);
      end
    end

    // constrained random
    for (int r = 0; r < 120; r++) begin
      convert(int'($urandom_range(4 * (1 << N) - 1, 0)), $urandom_range(1, 0) == 1);
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule